// File: doc/BRIEF.md
# Relay Overcurrent Guard with Switch-Release Recovery

This block sits between a wiper sequencer and the relay driver stage. It passes the sequencer's relay request through to the relay drive. It also watches a comparator flag that reports relay coil current above 500 mA. A flag that stays high across a qualifying window, counted on a 1 ms timebase tick, is treated as a short circuit. The block then latches a fault and keeps the relay drive off.

The fault is not cleared by a timer or by software. It clears when the operator releases both the interval switch and the wash switch. If the short is still present when either switch is pressed again, the fault latches again. During a load-dump event the output stage is forced conductive, so that it can absorb the pulse. Fault detection is blanked for the whole event, and any partly counted window is discarded.

Top module: `relay_guard`

## Requirements
- R1: While `rst` is high, and on the first edge with it high, `relay_drive` and `fault_held` are both driven low, whatever the request.
- R2: `fault_held` rises only after `overcur` has stayed high, with `load_dump` low, across DEBOUNCE_TICKS (default 10) pulses of `tick_1ms`. It goes high within two clock cycles of the last of those ticks. A run of fewer ticks sets nothing, and any low cycle of `overcur` restarts the count from zero.
- R3: While `fault_held` is high and `load_dump` is low, `relay_drive` stays low even with `relay_req` high.
- R4: `fault_held` clears on the clock edge after both `sw_interval` and `sw_wash` are low. It holds while either of them is high.
- R5: After a clear, if the qualified overcurrent is still present when either switch goes high again, `fault_held` sets again on the next edge, with no new counting window.
- R6: `load_dump` high forces `relay_drive` high on the next edge, regardless of `relay_req` and `fault_held`.
- R7: While `load_dump` is high, no fault is set and the qualifying count is held at zero. After load-dump ends, a full window of DEBOUNCE_TICKS ticks is needed again.
- R8: With no fault and no load-dump, `relay_drive` follows `relay_req` one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| tick_1ms | input | 1 | One-cycle timebase pulse, once per millisecond |
| relay_req | input | 1 | Relay request from the wiper sequencer |
| overcur | input | 1 | Overcurrent comparator flag (coil current above 500 mA) |
| load_dump | input | 1 | Load-dump indication |
| sw_interval | input | 1 | Interval switch level, high when closed |
| sw_wash | input | 1 | Wash switch level, high when closed |
| relay_drive | output | 1 | Registered relay driver enable |
| fault_held | output | 1 | Registered short-circuit latch status |

## Verification
The assertions take every input to be synchronous to `clk` and `tick_1ms` to be a single-cycle pulse. They also take reset to be applied on the first edges, so that the one-cycle history they inspect is always defined. The stimulus changes inputs only on falling edges and issues each tick as a one-cycle pulse followed by an idle cycle. It lets two idle cycles pass before each observation, so both output registers have settled after every change.

// File: rtl/relay_guard_pkg.sv
package relay_guard_pkg;

  typedef struct packed {
    logic interval;
    logic wash;
  } sw_pair_t;

  function automatic logic sw_all_open(input sw_pair_t s);
    return ~(s.interval | s.wash);
  endfunction

endpackage

// File: rtl/rg_oc_qualifier.sv
module rg_oc_qualifier #(
  parameter int unsigned DEBOUNCE_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1ms,
  input  logic overcur,
  input  logic blank,
  output logic qualified
);
  localparam int unsigned CW = $clog2(DEBOUNCE_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEBOUNCE_TICKS);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || blank || !overcur) begin
      run_cnt <= '0;
    end else if (tick_1ms && run_cnt != LIMIT) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign qualified = overcur && !blank && (run_cnt == LIMIT);
endmodule

// File: rtl/rg_fault_latch.sv
module rg_fault_latch
  import relay_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     set_req,
  input  sw_pair_t sw,
  output logic     fault_next,
  output logic     fault_q
);
  always_comb begin
    if (sw_all_open(sw)) begin
      fault_next = 1'b0;
    end else if (set_req) begin
      fault_next = 1'b1;
    end else begin
      fault_next = fault_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault_next;
    end
  end
endmodule

// File: rtl/rg_drive_stage.sv
module rg_drive_stage (
  input  logic clk,
  input  logic rst,
  input  logic relay_req,
  input  logic fault_next,
  input  logic force_on,
  output logic drive_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
    end else begin
      drive_q <= force_on | (relay_req & ~fault_next);
    end
  end
endmodule

// File: rtl/relay_guard.sv
module relay_guard
  import relay_guard_pkg::*;
#(
  parameter int unsigned DEBOUNCE_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1ms,
  input  logic relay_req,
  input  logic overcur,
  input  logic load_dump,
  input  logic sw_interval,
  input  logic sw_wash,
  output logic relay_drive,
  output logic fault_held
);
  logic     short_seen;
  logic     fault_nxt;
  sw_pair_t sw_now;

  assign sw_now.interval = sw_interval;
  assign sw_now.wash     = sw_wash;

  rg_oc_qualifier #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) qual_i (
    .clk       (clk),
    .rst       (rst),
    .tick_1ms  (tick_1ms),
    .overcur   (overcur),
    .blank     (load_dump),
    .qualified (short_seen)
  );

  rg_fault_latch latch_i (
    .clk        (clk),
    .rst        (rst),
    .set_req    (short_seen),
    .sw         (sw_now),
    .fault_next (fault_nxt),
    .fault_q    (fault_held)
  );

  rg_drive_stage drv_i (
    .clk        (clk),
    .rst        (rst),
    .relay_req  (relay_req),
    .fault_next (fault_nxt),
    .force_on   (load_dump),
    .drive_q    (relay_drive)
  );
endmodule

// File: rtl/relay_guard_chk.sv
module relay_guard_chk (
  input logic clk,
  input logic rst,
  input logic overcur,
  input logic load_dump,
  input logic sw_interval,
  input logic sw_wash,
  input logic relay_drive,
  input logic fault_held
);
  p_reset_off_r1: assert property (@(posedge clk)
    rst |=> (!relay_drive && !fault_held));

  p_set_needs_oc_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_held) |-> $past(overcur));

  p_fault_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    fault_held |-> (relay_drive == $past(load_dump)));

  p_release_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (!sw_interval && !sw_wash) |=> !fault_held);

  p_ld_forces_on_r6: assert property (@(posedge clk) disable iff (rst)
    load_dump |=> relay_drive);

  p_ld_blanks_r7: assert property (@(posedge clk) disable iff (rst)
    (load_dump && !fault_held) |=> !fault_held);
endmodule

bind relay_guard relay_guard_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .overcur     (overcur),
  .load_dump   (load_dump),
  .sw_interval (sw_interval),
  .sw_wash     (sw_wash),
  .relay_drive (relay_drive),
  .fault_held  (fault_held)
);

// File: tb/relay_guard_tb_top.sv
module relay_guard_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1ms = 1'b0;
  logic relay_req = 1'b0;
  logic overcur = 1'b0;
  logic load_dump = 1'b0;
  logic sw_interval = 1'b0;
  logic sw_wash = 1'b0;
  logic relay_drive;
  logic fault_held;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  relay_guard #(.DEBOUNCE_TICKS(10)) dut_i (
    .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .relay_req(relay_req),
    .overcur(overcur), .load_dump(load_dump), .sw_interval(sw_interval),
    .sw_wash(sw_wash), .relay_drive(relay_drive), .fault_held(fault_held)
  );

  // fields: req[15:12] | relay_req oc ld sw_int sw_wash [11:7] | ticks [6:2] | drive [1] | fault [0]
  localparam int NV = 16;
  localparam logic [15:0] VEC [NV] = '{
    {4'd8, 5'b10010, 5'd0,  2'b10},  // R8 pass-through
    {4'd2, 5'b11010, 5'd9,  2'b10},  // R2 nine ticks: no fault
    {4'd2, 5'b10010, 5'd0,  2'b10},  // R2 dropout restarts count
    {4'd2, 5'b11010, 5'd9,  2'b10},  // R2 nine again
    {4'd2, 5'b11010, 5'd1,  2'b01},  // R2 tenth tick sets fault
    {4'd3, 5'b10010, 5'd0,  2'b01},  // R3 request ignored
    {4'd4, 5'b00000, 5'd0,  2'b00},  // R4 both released clears
    {4'd8, 5'b10010, 5'd0,  2'b10},  // R8 resume
    {4'd4, 5'b11001, 5'd10, 2'b01},  // R4 wash held keeps it latched
    {4'd4, 5'b01000, 5'd0,  2'b00},  // R4 clear while short persists
    {4'd5, 5'b11001, 5'd0,  2'b01},  // R5 re-latch on press
    {4'd6, 5'b01101, 5'd0,  2'b11},  // R6 forced on despite fault
    {4'd4, 5'b00000, 5'd0,  2'b00},  // R4 clear
    {4'd7, 5'b11110, 5'd15, 2'b10},  // R7 masked during load-dump
    {4'd7, 5'b11010, 5'd9,  2'b10},  // R7 requalify: nine not enough
    {4'd7, 5'b11010, 5'd1,  2'b01}   // R7 full window after load-dump
  };

  task automatic check(input int req, input logic exp_d, input logic exp_f);
    total++;
    if (relay_drive !== exp_d || fault_held !== exp_f) begin
      bad++;
      $display("FAIL R%0d: drive=%b fault=%b expected drive=%b fault=%b",
               req, relay_drive, fault_held, exp_d, exp_f);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    relay_req = 1'b1;
    @(negedge clk);
    check(1, 1'b0, 1'b0);  // R1 reset holds outputs low
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {relay_req, overcur, load_dump, sw_interval, sw_wash} = VEC[i][11:7];
      for (int t = 0; t < int'(VEC[i][6:2]); t++) begin
        tick_1ms = 1'b1;
        @(negedge clk);
        tick_1ms = 1'b0;
        @(negedge clk);
      end
      settle();
      check(int'(VEC[i][15:12]), VEC[i][1], VEC[i][0]);
    end

    // R1: reset during a latched fault clears it
    {relay_req, overcur, load_dump, sw_interval, sw_wash} = 5'b11010;
    settle();
    check(1, 1'b0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check(1, 1'b0, 1'b0);
    rst = 1'b0;
    overcur = 1'b0;
    settle();
    check(8, 1'b1, 1'b0);  // R8 after reset

    // R6: load-dump alone, no request, forces drive
    relay_req = 1'b0;
    load_dump = 1'b1;
    @(negedge clk);
    check(6, 1'b1, 1'b0);
    load_dump = 1'b0;
    @(negedge clk);
    check(8, 1'b0, 1'b0);  // R8 drive drops with request low

    finished = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule